// File: doc/BRIEF.md
# Multi-channel DMA interrupt status unit

This block gathers the event pulses of a multi-channel DMA engine (sixteen channels by default) and holds them in two status words: one for transfer completions, one for errors. Each channel has an interrupt enable bit. All channels share one interrupt line. Every status word can be written three ways: a plain write, a write that only sets the bits at 1 in the data, and a write that only clears the bits at 1 in the data. Software can therefore acknowledge one channel without a read-modify-write race.

The block sorts the stored flags into real errors and benign ones. A termination error that arrives together with a completion on the same channel is treated as benign. The real errors and the completions are packed into one event vector, with the errors on top. The index of the highest set bit is published, so a handler can service one event at a time, errors first. A real error on a channel also raises that channel's reset request bit in the channel control word. The bit stays raised until software clears it.

The register bus is a plain 32-bit write strobe with a byte address. Read data is combinational from the address. No stream interfaces exist; all pins are plain control or status.

Top module: `dmairq_top`

## Requirements
- R1: After reset the three status words read 0, and `irq`, `event_valid`, `event_vec` and `chan_rst` are 0.
- R2: A pulse on `done_pulse[i]` sets bit i of the completion word (byte 0x00). A pulse on `term_err_pulse[i]` sets bit i of the error word (byte 0x10). A pulse on `bus_err_pulse[i]` sets bit i and bit 16+i of the error word. All of these are visible one clock after the pulse.
- R3: Each word's alias is chosen by byte offset from the word's base. Offset +0 writes the value, +4 ORs the data in, and +8 clears only the bits at 1 in the data. A write at +0xC, or at an address with nonzero bits 1:0, changes nothing. A read of any of the four offsets returns the word's value. The completion word holds the per-channel interrupt enables in bits 31:16.
- R4: When a hardware event and a software write that would clear the same bit occur in the same cycle, the bit ends up set.
- R5: A channel has a real error when its error bit and bus bit (16+i) are both set. It also has a real error when its error bit is set while both its bus bit and its completion bit are clear.
- R6: `event_vec` carries the real errors in bits 31:16 and the completion flags in bits 15:0.
- R7: `event_idx` is the position of the highest set bit of `event_vec`. `event_valid` is 1 exactly when `event_vec` is nonzero.
- R8: `irq` is 1 when any channel has its completion bit or error bit set together with its enable bit.
- R9: A real error on channel i sets bit 16+i of the channel control word (byte 0x20) and `chan_rst[i]` one clock later. The bit stays set until it is cleared through the word's aliases after the error is gone. Bits 15:0 of that word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| done_pulse | input | 16 | Per-channel completion pulse |
| term_err_pulse | input | 16 | Per-channel termination error pulse |
| bus_err_pulse | input | 16 | Per-channel bus error pulse |
| irq | output | 1 | Shared interrupt line |
| event_vec | output | 32 | Classified event vector |
| event_valid | output | 1 | Some event pending |
| event_idx | output | 5 | Highest pending event bit |
| chan_rst | output | 16 | Per-channel reset request |

## Verification
Status bits, the event vector, the index and `irq` all follow the first clock edge after a pulse or bus write. The reset request bits follow one edge later, because they are registered from the classified error. Read data follows the address with no clock. The bench drives every input just after a rising edge and steps exactly one edge before it checks the first group of results. It takes one more step before it checks the reset request. Collision cases drive the event and the clearing write in the same cycle.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    SEL_DONE  = 2'd0,
    SEL_ERR   = 2'd1,
    SEL_CHCTL = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_IDLE  = 2'd3
  } alias_op_e;

  typedef struct packed {
    logic wr;
    logic set;
    logic clr;
  } wr_ctl_t;
endpackage

// File: rtl/dmairq_alias_reg.sv
module dmairq_alias_reg
  import dmairq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  wr_ctl_t      ctl,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  logic [W-1:0] sw_next;

  always_comb begin
    sw_next = q;
    if (ctl.wr)       sw_next = wdata;
    else if (ctl.set) sw_next = q | wdata;
    else if (ctl.clr) sw_next = q & ~wdata;
  end

  // hardware events override any software write in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= sw_next | hw_set;
  end

  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((q & $past(hw_set)) == $past(hw_set)));

  assert_clear_removes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clr && !ctl.wr && !ctl.set |=> ((q & $past(wdata) & ~$past(hw_set)) == '0));

  assert_clear_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.clr && !ctl.wr && !ctl.set |=>
      ((q & ~$past(wdata)) == (($past(q) | $past(hw_set)) & ~$past(wdata))));
endmodule

// File: rtl/dmairq_classify.sv
module dmairq_classify #(
  parameter int NCH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCH-1:0]   done,
  input  logic [NCH-1:0]   err,
  input  logic [NCH-1:0]   bus,
  input  logic [NCH-1:0]   en,
  output logic [NCH-1:0]   eff_err,
  output logic [2*NCH-1:0] evt_vec,
  output logic             irq
);
  logic [NCH-1:0] ch_irq;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    // bus errors always count; a termination error counts only without a completion
    assign eff_err[i] = err[i] & (bus[i] | ~done[i]);
    assign ch_irq[i]  = en[i] & (done[i] | err[i]);
  end

  assign evt_vec = {eff_err, done};
  assign irq     = |ch_irq;

  assert_done_masks_term_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((eff_err & done & ~bus) == '0));

  assert_bus_always_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ((eff_err & err & bus) == (err & bus)));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en == '0) |-> !irq);
endmodule

// File: rtl/dmairq_prio_enc.sv
module dmairq_prio_enc #(
  parameter int N = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  vec,
  output logic          valid,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign valid = |vec;

  assert_idx_highest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> ((vec >> idx) == N'(1)));

  assert_idle_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> (idx == '0));
endmodule

// File: rtl/dmairq_top.sv
module dmairq_top
  import dmairq_pkg::*;
#(
  parameter int NCH    = 16,
  parameter int ADDR_W = 6,
  localparam int DW    = 2 * NCH,
  localparam int IW    = $clog2(DW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NCH-1:0]  done_pulse,
  input  logic [NCH-1:0]  term_err_pulse,
  input  logic [NCH-1:0]  bus_err_pulse,
  output logic            irq,
  output logic [DW-1:0]   event_vec,
  output logic            event_valid,
  output logic [IW-1:0]   event_idx,
  output logic [NCH-1:0]  chan_rst
);
  reg_sel_e  sel;
  alias_op_e op;
  logic      aligned;
  wr_ctl_t   ctl_done, ctl_err, ctl_chan;

  logic [DW-1:0]  done_q, err_q;
  logic [NCH-1:0] chan_q;
  logic [NCH-1:0] eff_err;

  assign sel     = reg_sel_e'(bus_addr[5:4]);
  assign op      = alias_op_e'(bus_addr[3:2]);
  assign aligned = (bus_addr[1:0] == 2'b00);

  function automatic wr_ctl_t decode(input logic hit, input alias_op_e o);
    wr_ctl_t c;
    c.wr  = hit && (o == OP_WRITE);
    c.set = hit && (o == OP_SET);
    c.clr = hit && (o == OP_CLEAR);
    return c;
  endfunction

  always_comb begin
    ctl_done = decode(bus_wr && aligned && sel == SEL_DONE,  op);
    ctl_err  = decode(bus_wr && aligned && sel == SEL_ERR,   op);
    ctl_chan = decode(bus_wr && aligned && sel == SEL_CHCTL, op);
  end

  dmairq_alias_reg #(.W(DW)) u_done_reg (
    .clk(clk), .rst_n(rst_n), .ctl(ctl_done), .wdata(bus_wdata),
    .hw_set({{NCH{1'b0}}, done_pulse}), .q(done_q)
  );

  dmairq_alias_reg #(.W(DW)) u_err_reg (
    .clk(clk), .rst_n(rst_n), .ctl(ctl_err), .wdata(bus_wdata),
    .hw_set({bus_err_pulse, bus_err_pulse | term_err_pulse}), .q(err_q)
  );

  dmairq_alias_reg #(.W(NCH)) u_chan_reg (
    .clk(clk), .rst_n(rst_n), .ctl(ctl_chan), .wdata(bus_wdata[DW-1:NCH]),
    .hw_set(eff_err), .q(chan_q)
  );

  dmairq_classify #(.NCH(NCH)) u_classify (
    .clk(clk), .rst_n(rst_n),
    .done(done_q[NCH-1:0]), .err(err_q[NCH-1:0]), .bus(err_q[DW-1:NCH]),
    .en(done_q[DW-1:NCH]), .eff_err(eff_err), .evt_vec(event_vec), .irq(irq)
  );

  dmairq_prio_enc #(.N(DW)) u_prio (
    .clk(clk), .rst_n(rst_n), .vec(event_vec),
    .valid(event_valid), .idx(event_idx)
  );

  assign chan_rst = chan_q;

  always_comb begin
    unique case (sel)
      SEL_DONE:  bus_rdata = done_q;
      SEL_ERR:   bus_rdata = err_q;
      SEL_CHCTL: bus_rdata = {chan_q, {NCH{1'b0}}};
      default:   bus_rdata = '0;
    endcase
  end

  assert_rst_follows_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|eff_err) |=> ((chan_rst & $past(eff_err)) == $past(eff_err)));

  assert_pulse_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_pulse) |=> ((done_q[NCH-1:0] & $past(done_pulse)) == $past(done_pulse)));
endmodule

// File: tb/dmairq_top_test.sv
module dmairq_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] done_pulse = '0, term_err_pulse = '0, bus_err_pulse = '0;
  logic        irq, event_valid;
  logic [31:0] event_vec;
  logic [4:0]  event_idx;
  logic [15:0] chan_rst;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  dmairq_top uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .done_pulse(done_pulse),
    .term_err_pulse(term_err_pulse), .bus_err_pulse(bus_err_pulse), .irq(irq),
    .event_vec(event_vec), .event_valid(event_valid), .event_idx(event_idx),
    .chan_rst(chan_rst)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [5:0] a, input logic [31:0] exp);
    bus_addr = a;
    #0.5;
    check(req, $sformatf("read %h", a), bus_rdata, exp);
  endtask

  task automatic pulse(input logic [15:0] d, input logic [15:0] t, input logic [15:0] b);
    done_pulse = d; term_err_pulse = t; bus_err_pulse = b;
    step();
    done_pulse = '0; term_err_pulse = '0; bus_err_pulse = '0;
  endtask

  task automatic clear_all();
    wr(6'h00, 32'h0);
    wr(6'h10, 32'h0);
    wr(6'h20, 32'h0);
  endtask

  task automatic t_reset();
    rd_check("R1", 6'h00, 32'h0);
    rd_check("R1", 6'h10, 32'h0);
    rd_check("R1", 6'h20, 32'h0);
    check("R1", "irq", 32'(irq), 32'h0);
    check("R1", "valid", 32'(event_valid), 32'h0);
    check("R1", "vec", event_vec, 32'h0);
    check("R1", "chan_rst", 32'(chan_rst), 32'h0);
  endtask

  task automatic t_done_alias();
    pulse(16'h0008, 16'h0, 16'h0);
    rd_check("R2", 6'h00, 32'h0000_0008);
    check("R6", "vec", event_vec, 32'h0000_0008);
    check("R7", "idx", 32'(event_idx), 32'd3);
    check("R7", "valid", 32'(event_valid), 32'h1);
    check("R8", "irq disabled", 32'(irq), 32'h0);
    wr(6'h04, 32'h0008_0000);
    rd_check("R3", 6'h00, 32'h0008_0008);
    check("R8", "irq enabled", 32'(irq), 32'h1);
    rd_check("R3", 6'h04, 32'h0008_0008);
    rd_check("R3", 6'h08, 32'h0008_0008);
    rd_check("R3", 6'h0C, 32'h0008_0008);
    wr(6'h0C, 32'h0);
    rd_check("R3", 6'h00, 32'h0008_0008);
    wr(6'h01, 32'h0);
    rd_check("R3", 6'h00, 32'h0008_0008);
    wr(6'h08, 32'h0000_0008);
    rd_check("R3", 6'h00, 32'h0008_0000);
    check("R8", "irq after clear", 32'(irq), 32'h0);
    check("R7", "valid after clear", 32'(event_valid), 32'h0);
    clear_all();
  endtask

  task automatic t_term_err();
    pulse(16'h0, 16'h0020, 16'h0);
    rd_check("R2", 6'h10, 32'h0000_0020);
    check("R6", "vec", event_vec, 32'h0020_0000);
    check("R7", "idx", 32'(event_idx), 32'd21);
    check("R9", "rst not yet", 32'(chan_rst), 32'h0);
    step();
    check("R9", "chan_rst", 32'(chan_rst), 32'h0020);
    rd_check("R9", 6'h20, 32'h0020_0000);
    pulse(16'h0020, 16'h0, 16'h0);
    check("R5", "term masked by done", event_vec, 32'h0000_0020);
    check("R7", "idx", 32'(event_idx), 32'd5);
    wr(6'h00, 32'h0);
    wr(6'h10, 32'h0);
    wr(6'h28, 32'h0020_0000);
    check("R9", "rst cleared", 32'(chan_rst), 32'h0);
    rd_check("R9", 6'h20, 32'h0);
  endtask

  task automatic t_bus_err();
    pulse(16'h0080, 16'h0, 16'h0080);
    rd_check("R2", 6'h10, 32'h0080_0080);
    check("R5", "bus err with done", event_vec, 32'h0080_0080);
    check("R7", "idx", 32'(event_idx), 32'd23);
    wr(6'h00, 32'h0);
    wr(6'h10, 32'h0);
    wr(6'h28, 32'h0080_0000);
    check("R9", "rst cleared", 32'(chan_rst), 32'h0);
  endtask

  task automatic t_priority();
    pulse(16'h0400, 16'h0004, 16'h0);
    check("R6", "vec", event_vec, 32'h0004_0400);
    check("R7", "error first", 32'(event_idx), 32'd18);
    wr(6'h18, 32'h0000_0004);
    check("R7", "next event", 32'(event_idx), 32'd10);
    check("R6", "vec", event_vec, 32'h0000_0400);
    wr(6'h00, 32'h0);
    wr(6'h28, 32'hFFFF_0000);
    check("R7", "valid empty", 32'(event_valid), 32'h0);
  endtask

  task automatic t_collide();
    done_pulse = 16'h0002;
    bus_wr = 1'b1; bus_addr = 6'h08; bus_wdata = 32'h0000_0002;
    step();
    bus_wr = 1'b0; done_pulse = '0;
    rd_check("R4", 6'h00, 32'h0000_0002);
    term_err_pulse = 16'h0010;
    bus_wr = 1'b1; bus_addr = 6'h10; bus_wdata = 32'h0;
    step();
    bus_wr = 1'b0; term_err_pulse = '0;
    rd_check("R4", 6'h10, 32'h0000_0010);
    clear_all();
  endtask

  task automatic t_irq_err();
    wr(6'h04, 32'h0004_0000);
    check("R8", "enable alone", 32'(irq), 32'h0);
    pulse(16'h0, 16'h0004, 16'h0);
    check("R8", "irq from error", 32'(irq), 32'h1);
    wr(6'h18, 32'h0000_0004);
    check("R8", "irq after ack", 32'(irq), 32'h0);
    clear_all();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_done_alias();
    t_term_err();
    t_bus_err();
    t_priority();
    t_collide();
    t_irq_err();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule